// File: doc/BRIEF.md
# PLL Start-Up Sequencer

This block brings one clock PLL from its reset condition to a locked, selected clock source in response to a single start pulse. It captures the requested feedback, reference and two post-divider values, checks that each fits its control field, and then walks the PLL controls through a fixed order. The downstream clock mux is moved to the crystal first. Next the internal bypass, power-down, DAC power-down and integer/fractional mode controls are updated, and then the dividers are loaded. Each of these steps takes exactly one clock.

After the dividers are loaded, the sequencer watches the PLL lock bit. A timer sized in reference-clock cycles (cycles per microsecond times a microsecond budget) limits the wait. If lock appears, the mux is moved to the PLL output and the run ends with success. If the timer expires, the mux stays on the crystal and the run ends with a timeout. A request whose divider values do not fit their fields is refused without touching any control. The DAC power-down and mode controls are optional and are chosen at elaboration. When a control is absent, its step is left out of the sequence and its output is held at the reset level.

Top module: `pll_start_seq`

## Requirements
- R1: After reset: `pll_sel`=0 (crystal), `int_byp`=1, `pwr_dn`=1, `dac_pd`=1, `frac_en`=0, `div_word`=0, and `busy`, `done`, `ok`, `timeout` are all 0.
- R2: A start pulse sampled while idle with fitting arguments sets `busy` at that edge. `pll_sel` is driven to 0 on the next edge, and it stays 0 for the rest of the run until the final switch.
- R3: Counting the accepting edge as E0, the following controls update one step per edge. E1 clears `pll_sel`, E2 clears `int_byp` and E3 clears `pwr_dn`. When both optional controls are present, E4 clears `dac_pd` and E5 loads `frac_en`, followed by E6 for the feedback field, E7 for the reference field and E8 for both post-divider fields. Steps for absent controls are skipped, and the later steps move up.
- R4: `div_word` carries the reference divider in bits 5:0 and the feedback divider in bits 11:0 of the field at bits 17:6. Post-divider 1 sits at bits 26:24 and post-divider 2 at bits 29:27. All other bits are 0.
- R5: The lock bit is sampled once the post-dividers are loaded. The first edge that sees it high leads, one edge later, to `pll_sel`=1 together with a one-cycle `done`, `ok`=1, `timeout`=0 and `busy`=0.
- R6: If the lock bit stays low for LIMIT = CYC_PER_US*LOCK_US consecutive wait cycles, the last of those edges raises `done` and `timeout`=1 and leaves `ok`=0. `pll_sel` stays 0 (crystal).
- R7: A start pulse sampled while idle is refused when any request does not fit its field: reference needs 6 bits, feedback 12 bits, and each post-divider 3 bits. The same edge raises `done` with `ok`=0 and `timeout`=0. `busy` stays 0 and no control output or `div_word` changes.
- R8: A start pulse while `busy` is 1 is ignored. The running request keeps its captured values and its timing, and request inputs that change after acceptance have no effect.
- R9: `ok` and `timeout` change only on the edge that raises `done`. They hold the result of the last finished request until the next one finishes.
- R10: The mode step loads `frac_en` with the captured `frac_req` value (1 = fractional, 0 = integer).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled when idle |
| frac_req | input | 1 | Requested mode, 1 = fractional |
| ref_req | input | ARG_W | Requested reference divider |
| fb_req | input | ARG_W | Requested feedback divider |
| pd1_req | input | ARG_W | Requested post-divider 1 |
| pd2_req | input | ARG_W | Requested post-divider 2 |
| lock_in | input | 1 | PLL lock status bit |
| pll_sel | output | 1 | Clock mux select, 1 = PLL, 0 = crystal |
| int_byp | output | 1 | PLL internal bypass control |
| pwr_dn | output | 1 | PLL power-down control |
| dac_pd | output | 1 | Noise-cancel DAC power-down control |
| frac_en | output | 1 | Fractional mode enable |
| div_word | output | WORD_W | Packed divider control word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a request finishes |
| ok | output | 1 | Last request locked and switched |
| timeout | output | 1 | Last request timed out waiting for lock |

## Verification
On every cycle, the assertions check the following. The mux leaves the crystal only when `done` and `ok` are high and power-down and internal bypass are already cleared. Each control falls only after the one before it in the order. A timed-out result never coexists with the PLL selected, and result flags change only with `done`. The wait timer must advance by one each wait cycle. Only the bench scenarios can show the exact edge of each step and of lock and timeout for both the full and reduced variants, the field positions in the divider word, the refusal of each oversized argument, and that a mid-run start and input changes leave the captured request intact.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_XTAL,
      ST_IBYP,
      ST_PWR,
      ST_DAC,
      ST_MODE,
      ST_FB,
      ST_REF,
      ST_POST,
      ST_WAIT,
      ST_SWITCH
   } seq_st_e;

   // Successor of a single-cycle control step; optional steps are skipped.
   function automatic seq_st_e step_after(seq_st_e s, bit has_dac, bit has_mode);
      seq_st_e n;
      case (s)
         ST_IDLE: n = ST_XTAL;
         ST_XTAL: n = ST_IBYP;
         ST_IBYP: n = ST_PWR;
         ST_PWR:  n = has_dac ? ST_DAC : (has_mode ? ST_MODE : ST_FB);
         ST_DAC:  n = has_mode ? ST_MODE : ST_FB;
         ST_MODE: n = ST_FB;
         ST_FB:   n = ST_REF;
         ST_REF:  n = ST_POST;
         ST_POST: n = ST_WAIT;
         default: n = ST_IDLE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/pll_arg_check.sv
module pll_arg_check #(
   parameter int ARG_W = 16,
   parameter int REF_W = 6,
   parameter int FB_W  = 12,
   parameter int PD_W  = 3
) (
   input  logic [ARG_W-1:0] ref_req,
   input  logic [ARG_W-1:0] fb_req,
   input  logic [ARG_W-1:0] pd1_req,
   input  logic [ARG_W-1:0] pd2_req,
   output logic             fits
);
   logic ref_ok, fb_ok, pd1_ok, pd2_ok;

   // A value fits when nothing remains above its field width.
   always_comb begin
      ref_ok = ((ref_req >> REF_W) == '0);
      fb_ok  = ((fb_req  >> FB_W)  == '0);
      pd1_ok = ((pd1_req >> PD_W)  == '0);
      pd2_ok = ((pd2_req >> PD_W)  == '0);
      fits   = ref_ok && fb_ok && pd1_ok && pd2_ok;
   end

   initial begin
      assert (REF_W <= ARG_W && FB_W <= ARG_W && PD_W <= ARG_W)
         else $error("pll_arg_check: field wider than request port");
   end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
   parameter int LIMIT = 2000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == LAST);

   // R6: each wait cycle without expiry moves the count up by one
   p_tmr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !expired) |=> (!run || cnt == $past(cnt) + 1'b1));

   initial begin
      assert (LIMIT >= 2) else $error("pll_lock_timer: LIMIT below 2");
   end
endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs import pll_seq_pkg::*; #(
   parameter int REF_W    = 6,
   parameter int FB_W     = 12,
   parameter int PD_W     = 3,
   parameter bit HAS_DAC  = 1'b1,
   parameter bit HAS_MODE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_st_e          st,
   input  logic             frac_q,
   input  logic [REF_W-1:0] ref_q,
   input  logic [FB_W-1:0]  fb_q,
   input  logic [PD_W-1:0]  pd1_q,
   input  logic [PD_W-1:0]  pd2_q,
   output logic             pll_sel,
   output logic             int_byp,
   output logic             pwr_dn,
   output logic             dac_pd,
   output logic             frac_en,
   output logic [REF_W-1:0] ref_o,
   output logic [FB_W-1:0]  fb_o,
   output logic [PD_W-1:0]  pd1_o,
   output logic [PD_W-1:0]  pd2_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pll_sel <= 1'b0;
         int_byp <= 1'b1;
         pwr_dn  <= 1'b1;
         ref_o   <= '0;
         fb_o    <= '0;
         pd1_o   <= '0;
         pd2_o   <= '0;
      end else begin
         case (st)
            ST_XTAL:   pll_sel <= 1'b0;
            ST_IBYP:   int_byp <= 1'b0;
            ST_PWR:    pwr_dn  <= 1'b0;
            ST_FB:     fb_o    <= fb_q;
            ST_REF:    ref_o   <= ref_q;
            ST_POST: begin
               pd1_o <= pd1_q;
               pd2_o <= pd2_q;
            end
            ST_SWITCH: pll_sel <= 1'b1;
            default: ;
         endcase
      end
   end

   generate
      if (HAS_DAC) begin : g_dac
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            dac_pd <= 1'b1;
            else if (st == ST_DAC) dac_pd <= 1'b0;
         end
      end else begin : g_no_dac
         assign dac_pd = 1'b1;
      end

      if (HAS_MODE) begin : g_mode
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             frac_en <= 1'b0;
            else if (st == ST_MODE) frac_en <= frac_q;
         end
      end else begin : g_no_mode
         assign frac_en = 1'b0;
      end
   endgenerate

   // R3: internal bypass is released only with the mux already on crystal
   p_ibyp_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_byp) |-> !pll_sel);
   // R3: power-down is released only after the internal bypass
   p_pwr_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_dn) |-> !int_byp);
   // R3: dividers are loaded only once the PLL is powered
   p_div_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({fb_o, ref_o, pd1_o, pd2_o}) |-> (!pwr_dn && !int_byp));
   // R5: the PLL is selected only when it is powered and not bypassed
   p_sel_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_sel) |-> (!pwr_dn && !int_byp));
endmodule

// File: rtl/pll_start_seq.sv
module pll_start_seq import pll_seq_pkg::*; #(
   parameter int ARG_W      = 16,
   parameter int REF_W      = 6,
   parameter int FB_W       = 12,
   parameter int PD_W       = 3,
   parameter int PD1_LSB    = 24,
   parameter int WORD_W     = 32,
   parameter int CYC_PER_US = 100,
   parameter int LOCK_US    = 20000,
   parameter bit HAS_DAC    = 1'b1,
   parameter bit HAS_MODE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              frac_req,
   input  logic [ARG_W-1:0]  ref_req,
   input  logic [ARG_W-1:0]  fb_req,
   input  logic [ARG_W-1:0]  pd1_req,
   input  logic [ARG_W-1:0]  pd2_req,
   input  logic              lock_in,
   output logic              pll_sel,
   output logic              int_byp,
   output logic              pwr_dn,
   output logic              dac_pd,
   output logic              frac_en,
   output logic [WORD_W-1:0] div_word,
   output logic              busy,
   output logic              done,
   output logic              ok,
   output logic              timeout
);
   localparam int LIMIT   = CYC_PER_US * LOCK_US;
   localparam int FB_LSB  = REF_W;
   localparam int PD2_LSB = PD1_LSB + PD_W;

   seq_st_e          st_q, st_nx;
   logic             args_fit, tmo_hit, accept, reject, lock_end, tmo_end;
   logic             frac_q;
   logic [REF_W-1:0] ref_q, ref_o;
   logic [FB_W-1:0]  fb_q, fb_o;
   logic [PD_W-1:0]  pd1_q, pd2_q, pd1_o, pd2_o;

   pll_arg_check #(.ARG_W(ARG_W), .REF_W(REF_W), .FB_W(FB_W), .PD_W(PD_W)) u_check (
      .ref_req(ref_req), .fb_req(fb_req), .pd1_req(pd1_req), .pd2_req(pd2_req),
      .fits(args_fit)
   );

   pll_lock_timer #(.LIMIT(LIMIT)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(st_q == ST_WAIT), .expired(tmo_hit)
   );

   assign accept   = start && (st_q == ST_IDLE) && args_fit;
   assign reject   = start && (st_q == ST_IDLE) && !args_fit;
   assign lock_end = (st_q == ST_SWITCH);
   assign tmo_end  = (st_q == ST_WAIT) && !lock_in && tmo_hit;

   always_comb begin
      case (st_q)
         ST_IDLE:   st_nx = accept ? ST_XTAL : ST_IDLE;
         ST_WAIT:   st_nx = lock_in ? ST_SWITCH : (tmo_hit ? ST_IDLE : ST_WAIT);
         ST_SWITCH: st_nx = ST_IDLE;
         default:   st_nx = step_after(st_q, HAS_DAC, HAS_MODE);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         frac_q  <= 1'b0;
         ref_q   <= '0;
         fb_q    <= '0;
         pd1_q   <= '0;
         pd2_q   <= '0;
         done    <= 1'b0;
         ok      <= 1'b0;
         timeout <= 1'b0;
      end else begin
         st_q <= st_nx;
         done <= reject || lock_end || tmo_end;
         if (accept) begin
            frac_q <= frac_req;
            ref_q  <= ref_req[REF_W-1:0];
            fb_q   <= fb_req[FB_W-1:0];
            pd1_q  <= pd1_req[PD_W-1:0];
            pd2_q  <= pd2_req[PD_W-1:0];
         end
         if (reject) begin
            ok      <= 1'b0;
            timeout <= 1'b0;
         end else if (lock_end) begin
            ok      <= 1'b1;
            timeout <= 1'b0;
         end else if (tmo_end) begin
            ok      <= 1'b0;
            timeout <= 1'b1;
         end
      end
   end

   assign busy = (st_q != ST_IDLE);

   pll_ctl_regs #(
      .REF_W(REF_W), .FB_W(FB_W), .PD_W(PD_W), .HAS_DAC(HAS_DAC), .HAS_MODE(HAS_MODE)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .st(st_q),
      .frac_q(frac_q), .ref_q(ref_q), .fb_q(fb_q), .pd1_q(pd1_q), .pd2_q(pd2_q),
      .pll_sel(pll_sel), .int_byp(int_byp), .pwr_dn(pwr_dn), .dac_pd(dac_pd),
      .frac_en(frac_en), .ref_o(ref_o), .fb_o(fb_o), .pd1_o(pd1_o), .pd2_o(pd2_o)
   );

   always_comb begin
      div_word = '0;
      div_word[REF_W-1:0]       = ref_o;
      div_word[FB_LSB +: FB_W]  = fb_o;
      div_word[PD1_LSB +: PD_W] = pd1_o;
      div_word[PD2_LSB +: PD_W] = pd2_o;
   end

   initial begin
      assert (FB_LSB + FB_W <= PD1_LSB) else $error("pll_start_seq: feedback overlaps post-divider");
      assert (PD2_LSB + PD_W <= WORD_W) else $error("pll_start_seq: post-divider beyond word");
      assert (LIMIT >= 2)               else $error("pll_start_seq: lock budget too small");
   end

   // R2: while running past the first step the mux stays on crystal
   p_xtal_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && st_q != ST_XTAL) |-> !pll_sel);
   // R5: the PLL is selected only together with a successful finish
   p_sel_with_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_sel) |-> (done && ok && !timeout));
   // R6: a timed-out result never leaves the PLL selected
   p_tmo_on_xtal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> !pll_sel);
   // R7: a refusal finishes straight from idle without a run
   p_reject_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ok && !timeout) |-> (!busy && $past(st_q == ST_IDLE)));
   // R8: a run ends only through a finish pulse
   p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R9: result flags move only on the finishing edge
   p_result_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({ok, timeout}) |-> done);
endmodule

// File: tb/pll_start_seq_test.sv
module pll_lock_model (
   input  logic        clk,
   input  logic        busy,
   input  int unsigned dly,
   output logic        lock
);
   int unsigned cnt;
   always_ff @(posedge clk) begin
      if (!busy) cnt <= 0;
      else       cnt <= cnt + 1;
   end
   assign lock = busy && (cnt >= dly);
endmodule

module pll_start_seq_test;
   localparam int CLK_P = 10;
   localparam int ARG_W = 16;
   localparam int CPU   = 2;
   localparam int LUS   = 20;
   localparam int LIMIT = CPU * LUS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic frac_req = 1'b0;
   logic [ARG_W-1:0] ref_req = '0, fb_req = '0, pd1_req = '0, pd2_req = '0;
   int unsigned dly = 20;

   logic lock_a, lock_b;
   logic sel_a, ibyp_a, pwr_a, dac_a, frac_a, busy_a, done_a, ok_a, tmo_a;
   logic sel_b, ibyp_b, pwr_b, dac_b, frac_b, busy_b, done_b, ok_b, tmo_b;
   logic [31:0] word_a, word_b;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   pll_start_seq #(.ARG_W(ARG_W), .CYC_PER_US(CPU), .LOCK_US(LUS)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .frac_req(frac_req),
      .ref_req(ref_req), .fb_req(fb_req), .pd1_req(pd1_req), .pd2_req(pd2_req),
      .lock_in(lock_a), .pll_sel(sel_a), .int_byp(ibyp_a), .pwr_dn(pwr_a),
      .dac_pd(dac_a), .frac_en(frac_a), .div_word(word_a), .busy(busy_a),
      .done(done_a), .ok(ok_a), .timeout(tmo_a)
   );

   pll_start_seq #(.ARG_W(ARG_W), .CYC_PER_US(CPU), .LOCK_US(LUS),
                   .HAS_DAC(1'b0), .HAS_MODE(1'b0)) uut_lean (
      .clk(clk), .rst_n(rst_n), .start(start), .frac_req(frac_req),
      .ref_req(ref_req), .fb_req(fb_req), .pd1_req(pd1_req), .pd2_req(pd2_req),
      .lock_in(lock_b), .pll_sel(sel_b), .int_byp(ibyp_b), .pwr_dn(pwr_b),
      .dac_pd(dac_b), .frac_en(frac_b), .div_word(word_b), .busy(busy_b),
      .done(done_b), .ok(ok_b), .timeout(tmo_b)
   );

   pll_lock_model m_a (.clk(clk), .busy(busy_a), .dly(dly), .lock(lock_a));
   pll_lock_model m_b (.clk(clk), .busy(busy_b), .dly(dly), .lock(lock_b));

   function automatic logic [31:0] wexp(int r, int f, int p1, int p2);
      return (32'(p2) << 27) | (32'(p1) << 24) | (32'(f) << 6) | 32'(r);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Drives a one-cycle start at a negedge; returns at the next negedge (N1).
   task automatic kick(input logic [15:0] r, input logic [15:0] f,
                       input logic [15:0] p1, input logic [15:0] p2, input logic fr);
      ref_req = r; fb_req = f; pd1_req = p1; pd2_req = p2; frac_req = fr;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "pll_sel", 32'(sel_a), 0);
      chk("R1", "int_byp", 32'(ibyp_a), 1);
      chk("R1", "pwr_dn", 32'(pwr_a), 1);
      chk("R1", "dac_pd", 32'(dac_a), 1);
      chk("R1", "frac_en", 32'(frac_a), 0);
      chk("R1", "div_word", word_a, 0);
      chk("R1", "busy/done/ok/timeout", {28'd0, busy_a, done_a, ok_a, tmo_a}, 0);
      chk("R1", "lean dac_pd", 32'(dac_b), 1);
   endtask

   task automatic t_order;
      dly = 20;
      kick(16'd37, 16'hABC, 16'd5, 16'd3, 1'b1);
      chk("R2", "busy at N1", 32'(busy_a), 1);
      step(1); // N2
      chk("R2", "sel cleared", 32'(sel_a), 0);
      chk("R3", "ibyp before step", 32'(ibyp_a), 1);
      step(1); // N3
      chk("R3", "ibyp step E2", {30'd0, ibyp_a, pwr_a}, 32'b01);
      step(1); // N4
      chk("R3", "pwr step E3", {30'd0, pwr_a, dac_a}, 32'b01);
      chk("R3", "lean pwr E3", 32'(pwr_b), 0);
      step(1); // N5
      chk("R3", "dac step E4", {30'd0, dac_a, frac_a}, 32'b00);
      chk("R3", "lean fb at E4", word_b, wexp(0, 'hABC, 0, 0));
      step(1); // N6
      chk("R10", "frac loaded E5", 32'(frac_a), 1);
      chk("R3", "word untouched E5", word_a, 0);
      chk("R3", "lean ref at E5", word_b, wexp(37, 'hABC, 0, 0));
      step(1); // N7
      chk("R4", "fb field E6", word_a, wexp(0, 'hABC, 0, 0));
      chk("R4", "lean full E6", word_b, wexp(37, 'hABC, 5, 3));
      chk("R3", "lean optional held", {30'd0, dac_b, frac_b}, 32'b10);
      step(1); // N8
      chk("R4", "ref field E7", word_a, wexp(37, 'hABC, 0, 0));
      step(1); // N9
      chk("R4", "post fields E8", word_a, wexp(37, 'hABC, 5, 3));
      step(13); // N22
      chk("R5", "no done before lock", {30'd0, done_a, sel_a}, 0);
      step(1); // N23
      chk("R5", "finish ok", {27'd0, done_a, ok_a, tmo_a, sel_a, busy_a}, 32'b11010);
      chk("R5", "lean finish ok", {27'd0, done_b, ok_b, tmo_b, sel_b, busy_b}, 32'b11010);
      step(1); // N24
      chk("R9", "done one cycle, ok held", {29'd0, done_a, ok_a, sel_a}, 32'b011);
   endtask

   task automatic t_ignore;
      dly = 20;
      kick(16'd12, 16'h155, 16'd2, 16'd7, 1'b0);
      step(1); // N2
      chk("R2", "sel back to crystal", 32'(sel_a), 0);
      chk("R9", "ok held during run", 32'(ok_a), 1);
      step(1); // N3
      ref_req = 16'd1; fb_req = 16'd1; pd1_req = 16'd1; pd2_req = 16'd1; frac_req = 1'b1;
      start = 1'b1;
      step(1); // N4
      start = 1'b0;
      chk("R8", "still busy", 32'(busy_a), 1);
      step(19); // N23
      chk("R8", "finish on time", {30'd0, done_a, ok_a}, 32'b11);
      chk("R8", "captured word kept", word_a, wexp(12, 'h155, 2, 7));
      chk("R8", "captured mode kept", 32'(frac_a), 0);
      step(2); // N25
      chk("R8", "no second run", 32'(busy_a), 0);
   endtask

   task automatic t_timeout;
      dly = 1000;
      kick(16'd63, 16'hFFF, 16'd7, 16'd0, 1'b1);
      step(8); // N9
      chk("R4", "max field values", word_a, wexp(63, 'hFFF, 7, 0));
      step(1); // N10
      chk("R9", "ok held while waiting", 32'(ok_a), 1);
      step(LIMIT - 2); // N48
      chk("R6", "waiting before expiry", {30'd0, done_a, busy_a}, 32'b01);
      step(1); // N49
      chk("R6", "timeout finish", {27'd0, done_a, ok_a, tmo_a, sel_a, busy_a}, 32'b10100);
      step(1); // N50
      chk("R9", "timeout held", {30'd0, tmo_a, sel_a}, 32'b10);
   endtask

   task automatic t_reject;
      logic [31:0] w0;
      w0 = word_a;
      dly = 20;
      kick(16'd1, 16'h1000, 16'd1, 16'd1, 1'b0);
      chk("R7", "fb too wide refused", {27'd0, done_a, ok_a, tmo_a, busy_a, pwr_a}, 32'b10000);
      chk("R7", "word untouched", word_a, w0);
      step(1);
      chk("R7", "no run after refusal", {30'd0, done_a, busy_a}, 0);
      kick(16'd1, 16'd1, 16'd8, 16'd1, 1'b0);
      chk("R7", "pd1 too wide refused", {29'd0, done_a, ok_a, busy_a}, 32'b100);
      step(1);
      kick(16'd64, 16'd1, 16'd1, 16'd1, 1'b0);
      chk("R7", "ref too wide refused", {29'd0, done_a, ok_a, busy_a}, 32'b100);
      step(1);
      kick(16'd1, 16'd1, 16'd1, 16'h0100, 1'b0);
      chk("R7", "pd2 too wide refused", {29'd0, done_a, ok_a, busy_a}, 32'b100);
      chk("R7", "controls untouched", {29'd0, sel_a, frac_a, ibyp_a}, 32'b010);
      step(1);
   endtask

   initial begin
      step(3);
      t_reset;
      rst_n = 1'b1;
      step(2);
      t_order;
      step(2);
      t_ignore;
      step(2);
      t_timeout;
      step(2);
      t_reject;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule